// File: doc/BRIEF.md
# Receive FIFO with trigger flag

This block buffers received bytes for a serial port. The deserializer hands over each finished byte with a one-cycle push strobe. The bytes sit in a 64-entry first-in first-out store until the CPU or a DMA engine pops them. The oldest byte is always visible on the CPU read-data port, and a pop strobe consumes it. A fill-count output reports how many bytes are stored at any moment.

A sticky threshold flag tells software that enough bytes have arrived. The threshold comes from a 2-bit trigger code. The flag sets as soon as the stored count reaches the threshold. Once set, it stays set even when the count drops, until one of two things happens:

- Software clears it through a read-then-write handshake.
- A DMA pop takes the count below the threshold.

A push that finds the store full, with no pop in the same cycle, is lost and raises a sticky overrun bit.

Top module: `rx_trig_fifo`

## Requirements
- R1: While reset is active, and in the first cycle after it, fill_count is 0, trig_flag is 0, overrun is 0 and the trigger code is 0.
- R2: Bytes leave in the order they arrived. Up to 64 bytes are held. cpu_rdata always shows the oldest stored byte, and a pop (cpu_pop or dma_pop, or both, which counts as one pop) removes it.
- R3: fill_count equals the number of stored bytes, updated one cycle after the strobes. An accepted push and a pop in the same cycle leave the count unchanged, and this includes the case where the store is full.
- R4: A pop while the store is empty changes neither the count nor the read position. The next pushed byte then appears on cpu_rdata.
- R5: A push while 64 bytes are stored, without a pop in the same cycle, is discarded. It sets overrun, which stays at 1 until reset. Filling to exactly 64 bytes does not set overrun.
- R6: The trigger code, written through cpu_trig_wr and cpu_trig_wdata, selects the threshold. Code 0 selects 1 byte, code 1 selects 16, code 2 selects 32 and code 3 selects 48. A new code applies from the cycle after the write.
- R7: trig_flag is 1 in the cycle after any update that leaves the count at or above the threshold. It does not drop merely because the count falls.
- R8: Software clears trig_flag in a set order. First, cpu_stat_rd is pulsed while trig_flag is 1; this arms the clear. Then the count falls below the threshold. Then a write of 0 is made with cpu_flag_wr and cpu_flag_wdata=0. The clear takes effect in the cycle after that write.
- R9: A write of 1 to the flag has no effect. A write of 0 has no effect when the clear has not been armed, or while the count is still at or above the threshold.
- R10: A DMA pop that takes the count below the threshold clears trig_flag without any software write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | Deserializer byte-ready strobe |
| rx_byte | input | 8 | Byte from the deserializer |
| cpu_pop | input | 1 | CPU data read: consumes the oldest byte |
| cpu_rdata | output | 8 | Oldest stored byte (undefined when empty) |
| cpu_stat_rd | input | 1 | CPU status read; arms the flag clear when trig_flag is 1 |
| cpu_flag_wr | input | 1 | CPU write strobe for the flag |
| cpu_flag_wdata | input | 1 | Value written to the flag |
| cpu_trig_wr | input | 1 | CPU write strobe for the trigger code |
| cpu_trig_wdata | input | 2 | New trigger code |
| dma_pop | input | 1 | DMA read strobe: consumes the oldest byte |
| trig_flag | output | 1 | Sticky threshold flag |
| overrun | output | 1 | Sticky lost-byte indicator |
| fill_count | output | 7 | Number of stored bytes, 0 to 64 |

## Verification
The assertions assume that every input strobe is a plain level sampled once per clock. They also assume that cpu_flag_wdata and cpu_trig_wdata have a known value whenever their write strobes are high. The stimulus meets this by changing inputs only a short delay after the rising edge and returning every strobe to 0 after one cycle.

The assertions do not assume that pops avoid an empty store or that pushes avoid a full one. The bench deliberately pops when empty, pushes when full, and issues pushes and pops together, so that these paths are exercised under the same checks.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef logic [1:0] trig_code_t;

    // Threshold for a trigger code: code 0 gives a single byte, other codes step in quarters of the depth.
    function automatic int unsigned trig_level(input trig_code_t code, input int unsigned depth);
        if (code == 2'd0) return 1;
        return int'(unsigned'(code)) * (depth / 4);
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] count_nxt_o,
    output logic          nonempty_o,
    output logic          ovr_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic pop_ok, push_ok;

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop_i && (st_q.cnt != '0);
        push_ok = push_i && ((st_q.cnt != FULL_CNT) || pop_ok);
        if (push_ok) st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (push_i && !push_ok) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= data_i;
    end

    assign rdata_o     = mem_q[st_q.rp];
    assign count_o     = st_q.cnt;
    assign count_nxt_o = st_d.cnt;
    assign nonempty_o  = (st_q.cnt != '0);
    assign ovr_o       = st_q.ovr;

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // R3
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && st_q.cnt != '0) |=> $stable(st_q.cnt));

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.cnt == '0) |=> (st_q.cnt == '0) && $stable(st_q.rp));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && st_q.cnt == FULL_CNT) |=> st_q.ovr && (st_q.cnt == FULL_CNT));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);

endmodule

// File: rtl/rxf_flag.sv
module rxf_flag #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       cnt_i,
    input  logic [CW-1:0]       cnt_nxt_i,
    input  logic                dma_pop_i,
    input  logic                stat_rd_i,
    input  logic                flag_wr_i,
    input  logic                flag_wdata_i,
    input  logic                trig_wr_i,
    input  rxf_pkg::trig_code_t trig_wdata_i,
    output logic                flag_o
);
    typedef struct packed {
        logic                flag;
        logic                armed;
        rxf_pkg::trig_code_t trig;
    } fl_t;

    fl_t fl_d, fl_q;
    logic [CW-1:0] lvl;
    logic at_or_above, sw_clr, dma_clr;

    always_comb begin
        fl_d        = fl_q;
        lvl         = CW'(rxf_pkg::trig_level(fl_q.trig, DEPTH));
        at_or_above = (cnt_nxt_i >= lvl);
        sw_clr      = flag_wr_i && !flag_wdata_i && fl_q.armed && !at_or_above;
        dma_clr     = dma_pop_i && !at_or_above;
        if (at_or_above)           fl_d.flag = 1'b1;
        else if (sw_clr || dma_clr) fl_d.flag = 1'b0;
        if (!fl_d.flag)                    fl_d.armed = 1'b0;
        else if (stat_rd_i && fl_q.flag)   fl_d.armed = 1'b1;
        if (trig_wr_i) fl_d.trig = trig_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag_o = fl_q.flag;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_nxt_i >= lvl) |=> fl_q.flag);

    // R7
    flag_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_q.flag) |-> (cnt_i < $past(lvl)));

    // R8
    sw_clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_q.flag) && !$past(dma_pop_i)) |->
            ($past(fl_q.armed) && $past(flag_wr_i) && !$past(flag_wdata_i)));

    // R9
    write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.flag && flag_wr_i && flag_wdata_i && !dma_pop_i) |=> fl_q.flag);

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    input  logic          cpu_pop,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cpu_stat_rd,
    input  logic          cpu_flag_wr,
    input  logic          cpu_flag_wdata,
    input  logic          cpu_trig_wr,
    input  logic [1:0]    cpu_trig_wdata,
    input  logic          dma_pop,
    output logic          trig_flag,
    output logic          overrun,
    output logic [CW-1:0] fill_count
);
    logic [CW-1:0] cnt_nxt;
    logic          nonempty;
    logic          dma_take;

    assign dma_take = dma_pop && nonempty;

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_push),
        .data_i      (rx_byte),
        .pop_i       (cpu_pop || dma_pop),
        .rdata_o     (cpu_rdata),
        .count_o     (fill_count),
        .count_nxt_o (cnt_nxt),
        .nonempty_o  (nonempty),
        .ovr_o       (overrun)
    );

    rxf_flag #(.DEPTH(DEPTH)) u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (fill_count),
        .cnt_nxt_i    (cnt_nxt),
        .dma_pop_i    (dma_take),
        .stat_rd_i    (cpu_stat_rd),
        .flag_wr_i    (cpu_flag_wr),
        .flag_wdata_i (cpu_flag_wdata),
        .trig_wr_i    (cpu_trig_wr),
        .trig_wdata_i (cpu_trig_wdata),
        .flag_o       (trig_flag)
    );

endmodule

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       cpu_pop = 1'b0;
    logic [7:0] cpu_rdata;
    logic       cpu_stat_rd = 1'b0;
    logic       cpu_flag_wr = 1'b0;
    logic       cpu_flag_wdata = 1'b0;
    logic       cpu_trig_wr = 1'b0;
    logic [1:0] cpu_trig_wdata = '0;
    logic       dma_pop = 1'b0;
    logic       trig_flag;
    logic       overrun;
    logic [6:0] fill_count;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rx_trig_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte),
        .cpu_pop(cpu_pop), .cpu_rdata(cpu_rdata), .cpu_stat_rd(cpu_stat_rd),
        .cpu_flag_wr(cpu_flag_wr), .cpu_flag_wdata(cpu_flag_wdata),
        .cpu_trig_wr(cpu_trig_wr), .cpu_trig_wdata(cpu_trig_wdata),
        .dma_pop(dma_pop), .trig_flag(trig_flag), .overrun(overrun),
        .fill_count(fill_count)
    );

    // {push, byte, cpu_pop, dma_pop, exp_count, exp_flag, exp_head}; trigger code 0 (threshold 1)
    localparam int NVEC = 10;
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b1, 8'hA5, 1'b0, 1'b0, 7'd1, 1'b1, 8'hA5},
        {1'b1, 8'h3C, 1'b0, 1'b0, 7'd2, 1'b1, 8'hA5},
        {1'b0, 8'h00, 1'b1, 1'b0, 7'd1, 1'b1, 8'h3C},
        {1'b1, 8'h5A, 1'b1, 1'b0, 7'd1, 1'b1, 8'h5A},
        {1'b0, 8'h00, 1'b0, 1'b1, 7'd0, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b0, 1'b1, 7'd0, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b0, 7'd0, 1'b0, 8'h00},
        {1'b1, 8'h11, 1'b0, 1'b0, 7'd1, 1'b1, 8'h11},
        {1'b0, 8'h00, 1'b1, 1'b0, 7'd0, 1'b1, 8'h00},
        {1'b1, 8'h22, 1'b0, 1'b1, 7'd1, 1'b1, 8'h22}
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock; outputs are then stable for sampling and all strobes return low.
    task automatic tick();
        @(posedge clk);
        #2;
        rx_push = 1'b0; cpu_pop = 1'b0; dma_pop = 1'b0; cpu_stat_rd = 1'b0;
        cpu_flag_wr = 1'b0; cpu_trig_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic push_n(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_push = 1'b1; rx_byte = base + 8'(i);
            tick();
        end
    endtask

    task automatic set_trig(input logic [1:0] code);
        cpu_trig_wr = 1'b1; cpu_trig_wdata = code;
        tick();
    endtask

    initial begin
        do_reset();
        tick();
        // R1 reset state
        check("R1 count", int'(fill_count), 0);
        check("R1 flag", int'(trig_flag), 0);
        check("R1 overrun", int'(overrun), 0);

        // Vector table: R2 R3 R4 R7 R10 under threshold 1
        for (int v = 0; v < NVEC; v++) begin
            rx_push = VEC[v][26]; rx_byte = VEC[v][25:18];
            cpu_pop = VEC[v][17]; dma_pop = VEC[v][16];
            tick();
            check($sformatf("R3 count vec%0d", v), int'(fill_count), int'(VEC[v][15:9]));
            check($sformatf("R7 flag vec%0d", v), int'(trig_flag), int'(VEC[v][8]));
            if (VEC[v][15:9] != 7'd0)
                check($sformatf("R2 head vec%0d", v), int'(cpu_rdata), int'(VEC[v][7:0]));
        end

        // R1 reset clears a set flag and restores trigger code 0
        do_reset();
        check("R1 count after rerun", int'(fill_count), 0);
        check("R1 flag after rerun", int'(trig_flag), 0);

        // R2 ordering
        push_n(3, 8'h41);
        for (int i = 0; i < 3; i++) begin
            check("R2 order", int'(cpu_rdata), 8'h41 + i);
            cpu_pop = 1'b1;
            tick();
        end
        do_reset();

        // R6 code 1 = 16, R9 and R8 software protocol
        set_trig(2'd1);
        push_n(15, 8'h00);
        check("R6 below 16", int'(trig_flag), 0);
        push_n(1, 8'h0F);
        check("R6 at 16", int'(trig_flag), 1);
        cpu_flag_wr = 1'b1; cpu_flag_wdata = 1'b1; tick();
        check("R9 write one", int'(trig_flag), 1);
        cpu_pop = 1'b1; tick();
        check("R7 sticky at 15", int'(trig_flag), 1);
        cpu_flag_wr = 1'b1; cpu_flag_wdata = 1'b0; tick();
        check("R9 unarmed write zero", int'(trig_flag), 1);
        push_n(1, 8'h10);
        cpu_stat_rd = 1'b1; tick();
        cpu_flag_wr = 1'b1; cpu_flag_wdata = 1'b0; tick();
        check("R9 zero at threshold", int'(trig_flag), 1);
        cpu_pop = 1'b1; tick();
        cpu_flag_wr = 1'b1; cpu_flag_wdata = 1'b0; tick();
        check("R8 software clear", int'(trig_flag), 0);
        check("R8 count", int'(fill_count), 15);

        // R6 code 2 = 32, R10 DMA clear
        set_trig(2'd2);
        push_n(16, 8'h20);
        check("R6 below 32", int'(trig_flag), 0);
        push_n(1, 8'h30);
        check("R6 at 32", int'(trig_flag), 1);
        dma_pop = 1'b1; tick();
        check("R10 dma clear", int'(trig_flag), 0);
        check("R10 count", int'(fill_count), 31);

        // R6 code 3 = 48
        set_trig(2'd3);
        push_n(16, 8'h40);
        check("R6 below 48", int'(trig_flag), 0);
        push_n(1, 8'h50);
        check("R6 at 48", int'(trig_flag), 1);

        // R5 and R3 at full
        push_n(16, 8'h60);
        check("R5 full count", int'(fill_count), 64);
        check("R5 no overrun at 64", int'(overrun), 0);
        rx_push = 1'b1; rx_byte = 8'hEE; cpu_pop = 1'b1; tick();
        check("R3 push pop at full", int'(fill_count), 64);
        check("R5 no overrun with pop", int'(overrun), 0);
        rx_push = 1'b1; rx_byte = 8'hFF; tick();
        check("R5 dropped count", int'(fill_count), 64);
        check("R5 overrun set", int'(overrun), 1);
        cpu_pop = 1'b1; tick();
        check("R5 overrun sticky", int'(overrun), 1);
        check("R2 count after pop", int'(fill_count), 63);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule